// File: doc/BRIEF.md
# External Interrupt Request Aggregator

This block gathers a bank of independent external interrupt lines into one pending register, with one bit per line. Each line has its own enable bit. A single global enable, which mirrors the processor's interrupt-enable status bit, gates every maskable request. Whenever at least one enabled line is pending and the global enable is set, the block presents a request to the core on the fixed external-interrupt vector (4). Software reads the raw or the masked pending bits and acknowledges a line by writing a 1 to its bit.

Three other request classes share the same output. A power-failure warning (vector 2) and a low-priority machine check (vector 3) are maskable like the external lines. A high-priority machine check (vector 1) is non-maskable: it reaches the core whatever the global enable says. When several classes are active together, the lowest vector number wins. The request and its vector are registered, so they settle one clock after their cause.

Top module: `eir_aggregator`

## Requirements
- R1: While source input `src_i[i]` is high at a rising clock edge, pending bit i (register select 0) is 1 after that edge, and it stays 1 after the input drops until software clears it.
- R2: A write to register select 0 clears each pending bit whose data bit is 1 and leaves each pending bit whose data bit is 0 unchanged.
- R3: If a source is high in the same cycle as a write that clears its bit, the bit stays set.
- R4: Register select 1 is the per-source enable register (read/write, bit i enables source i). Register select 2 reads pending AND enable. Writes to selects 2 and 3 change nothing, and select 3 reads as zero.
- R5: When the global enable is 1 and pending AND enable is nonzero, `irq_req` is 1 with `irq_vec` = 4 one clock later (two clocks after the source rises), provided no higher-priority class is active.
- R6: While the global enable is 0, external lines, power failure and low-priority machine check raise no request, and pending bits are kept. A request appears one clock after the global enable returns to 1.
- R7: A high `hpmc_i` gives `irq_req` = 1 with `irq_vec` = 1 one clock later, whatever the global enable and other inputs.
- R8: With the global enable at 1, power failure gives vector 2 and low-priority machine check gives vector 3. The priority is vector 1 over 2 over 3 over 4.
- R9: When no request is raised, `irq_req` is 0 and `irq_vec` is 0.
- R10: After synchronous reset, pending bits, enable bits, `irq_req` and `irq_vec` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sampled external interrupt lines |
| glb_en_i | input | 1 | Global interrupt enable (processor status I bit) |
| pwrfail_i | input | 1 | Power-failure warning, maskable |
| lpmc_i | input | 1 | Low-priority machine check, maskable |
| hpmc_i | input | 1 | High-priority machine check, non-maskable |
| reg_sel_i | input | 2 | Register select: 0 pending, 1 enable, 2 masked pending, 3 reserved |
| reg_we_i | input | 1 | Write strobe for the register port |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| irq_req_o | output | 1 | Registered request to the core |
| irq_vec_o | output | 5 | Registered vector number of the winning request |

## Verification
The assertions take for granted that every input is synchronous to `clk` and free of unknown values once reset is released, and that the global enable and the three special request lines are held steady long enough to be sampled at an edge. The stimulus meets this by changing all inputs only on the falling edge and by leaving the register select at a defined value at all times. The checks on priority and gating assume the special lines stay level for the cycle they are sampled in, and the bench holds them across the whole observation window of each vector.

// File: rtl/eir_pkg.sv
package eir_pkg;

    localparam int VEC_W = 5;

    localparam logic [VEC_W-1:0] VEC_NONE = 5'd0;
    localparam logic [VEC_W-1:0] VEC_HPMC = 5'd1;
    localparam logic [VEC_W-1:0] VEC_PWR  = 5'd2;
    localparam logic [VEC_W-1:0] VEC_LPMC = 5'd3;
    localparam logic [VEC_W-1:0] VEC_EXT  = 5'd4;

    typedef enum logic [1:0] {
        SEL_PEND  = 2'd0,
        SEL_ENAB  = 2'd1,
        SEL_MPEND = 2'd2,
        SEL_RSVD  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } irq_t;

    // Fixed priority: lower vector number wins. Only the non-maskable
    // class ignores the global enable.
    function automatic irq_t pick_irq(input logic glb, input logic hpmc,
                                      input logic pwr, input logic lpmc,
                                      input logic ext);
        irq_t r;
        r.valid = 1'b1;
        if (hpmc)             r.vec = VEC_HPMC;
        else if (glb && pwr)  r.vec = VEC_PWR;
        else if (glb && lpmc) r.vec = VEC_LPMC;
        else if (glb && ext)  r.vec = VEC_EXT;
        else begin
            r.valid = 1'b0;
            r.vec   = VEC_NONE;
        end
        return r;
    endfunction

endpackage

// File: rtl/eir_capture.sv
module eir_capture #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] pend_q;

    // One sticky flop per source; a set in the same cycle beats a clear.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) pend_q[i] <= 1'b0;
            else     pend_q[i] <= src_i[i] | (pend_q[i] & ~clr_i[i]);
        end
    end

    assign pend_o = pend_q;

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (src_i != '0) |=> ((pend_q & $past(src_i)) == $past(src_i)));

    // R1
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/eir_enable.sv
module eir_enable #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] en_o
);

    logic [NUM_SRC-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)       en_q <= '0;
        else if (wr_i) en_q <= wdata_i;
    end

    assign en_o = en_q;

    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(en_q));

endmodule

// File: rtl/eir_arbiter.sv
module eir_arbiter
    import eir_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               glb_en_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               pwrfail_i,
    input  logic               lpmc_i,
    input  logic               hpmc_i,
    output logic [NUM_SRC-1:0] masked_o,
    output logic               req_o,
    output logic [VEC_W-1:0]   vec_o
);

    logic [NUM_SRC-1:0] masked;
    logic               ext_any;
    irq_t               nxt;
    irq_t               cur_q;

    assign masked  = pend_i & en_i;
    assign ext_any = |masked;

    always_comb nxt = pick_irq(glb_en_i, hpmc_i, pwrfail_i, lpmc_i, ext_any);

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '{valid: 1'b0, vec: VEC_NONE};
        else     cur_q <= nxt;
    end

    assign masked_o = masked;
    assign req_o    = cur_q.valid;
    assign vec_o    = cur_q.vec;

    // R7
    hpmc_chk: assert property (@(posedge clk) disable iff (rst)
        hpmc_i |=> (req_o && vec_o == VEC_HPMC));

    // R6
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!glb_en_i && !hpmc_i) |=> !req_o);

    // R8
    pwr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (glb_en_i && pwrfail_i && !hpmc_i) |=> (vec_o == VEC_PWR));

    // R5
    ext_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (glb_en_i && ext_any && !hpmc_i && !pwrfail_i && !lpmc_i)
            |=> (req_o && vec_o == VEC_EXT));

    // R9
    vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_o |-> (vec_o == VEC_NONE));

endmodule

// File: rtl/eir_aggregator.sv
module eir_aggregator
    import eir_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               glb_en_i,
    input  logic               pwrfail_i,
    input  logic               lpmc_i,
    input  logic               hpmc_i,
    input  logic [1:0]         reg_sel_i,
    input  logic               reg_we_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic [NUM_SRC-1:0] reg_rdata_o,
    output logic               irq_req_o,
    output logic [VEC_W-1:0]   irq_vec_o
);

    reg_sel_e           sel;
    logic               wr_pend;
    logic               wr_enab;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] masked;

    assign sel     = reg_sel_e'(reg_sel_i);
    assign wr_pend = reg_we_i && (sel == SEL_PEND);
    assign wr_enab = reg_we_i && (sel == SEL_ENAB);
    assign clr     = wr_pend ? reg_wdata_i : '0;

    eir_capture #(.NUM_SRC(NUM_SRC)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    eir_enable #(.NUM_SRC(NUM_SRC)) u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_enab),
        .wdata_i (reg_wdata_i),
        .en_o    (en)
    );

    eir_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .glb_en_i  (glb_en_i),
        .pend_i    (pend),
        .en_i      (en),
        .pwrfail_i (pwrfail_i),
        .lpmc_i    (lpmc_i),
        .hpmc_i    (hpmc_i),
        .masked_o  (masked),
        .req_o     (irq_req_o),
        .vec_o     (irq_vec_o)
    );

    always_comb begin
        unique case (sel)
            SEL_PEND:  reg_rdata_o = pend;
            SEL_ENAB:  reg_rdata_o = en;
            SEL_MPEND: reg_rdata_o = masked;
            default:   reg_rdata_o = '0;
        endcase
    end

endmodule

// File: tb/sim_eir_aggregator.sv
`timescale 1ns/1ps
module sim_eir_aggregator;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  src;
    logic          glb, pwr, lpmc, hpmc;
    logic [1:0]    sel;
    logic          we;
    logic [N-1:0]  wdata;
    logic [N-1:0]  rdata;
    logic          irq;
    logic [4:0]    vec;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    eir_aggregator #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst(rst), .src_i(src), .glb_en_i(glb),
        .pwrfail_i(pwr), .lpmc_i(lpmc), .hpmc_i(hpmc),
        .reg_sel_i(sel), .reg_we_i(we), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_req_o(irq), .irq_vec_o(vec)
    );

    typedef struct packed {
        logic [31:0] s;
        logic [31:0] e;
        logic        g, p, l, h;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{s: 32'h0000_0001, e: 32'h0000_0001, g: 1, p: 0, l: 0, h: 0},
        '{s: 32'h8000_0000, e: 32'h0000_0000, g: 1, p: 0, l: 0, h: 0},
        '{s: 32'h0000_F000, e: 32'h0000_1000, g: 0, p: 0, l: 0, h: 0},
        '{s: 32'h0000_0000, e: 32'hFFFF_FFFF, g: 0, p: 0, l: 0, h: 1},
        '{s: 32'h0000_0010, e: 32'h0000_0010, g: 1, p: 1, l: 0, h: 0},
        '{s: 32'h8000_0000, e: 32'h8000_0000, g: 0, p: 1, l: 1, h: 0},
        '{s: 32'h0000_A5A5, e: 32'h0000_FFFF, g: 1, p: 0, l: 1, h: 0},
        '{s: 32'h0000_00FF, e: 32'h0000_00FF, g: 1, p: 1, l: 1, h: 1}
    };

    function automatic logic [5:0] expect_irq(vec_t t);
        logic ext;
        ext = |(t.s & t.e);
        if (t.h)             return {1'b1, 5'd1};
        if (t.g && t.p)      return {1'b1, 5'd2};
        if (t.g && t.l)      return {1'b1, 5'd3};
        if (t.g && ext)      return {1'b1, 5'd4};
        return 6'd0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        sel = a; wdata = d; we = 1'b1;
        step();
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        sel = a;
        #0.5;
        d = rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [5:0]  ex;
        rst = 1'b1; src = '0; glb = 0; pwr = 0; lpmc = 0; hpmc = 0;
        sel = 2'd0; we = 0; wdata = '0;
        step(); step(); step();
        rst = 1'b0;
        step();

        // R10 reset state
        chk("R10 irq", {31'd0, irq}, 32'd0);
        chk("R10 vec", {27'd0, vec}, 32'd0);
        rd(2'd0, d); chk("R10 pend", d, 32'd0);
        rd(2'd1, d); chk("R10 enab", d, 32'd0);

        // Table walk: R5 R6 R7 R8 R9 and R4 masked read
        for (int k = 0; k < NV; k++) begin
            src = '0;
            wr(2'd0, 32'hFFFF_FFFF);
            wr(2'd1, TBL[k].e);
            src = TBL[k].s; glb = TBL[k].g; pwr = TBL[k].p;
            lpmc = TBL[k].l; hpmc = TBL[k].h;
            step();
            src = '0;
            step();
            ex = expect_irq(TBL[k]);
            chk($sformatf("R5/R6/R7/R8/R9 req row%0d", k), {31'd0, irq}, {31'd0, ex[5]});
            chk($sformatf("R8 vec row%0d", k), {27'd0, vec}, {27'd0, ex[4:0]});
            rd(2'd2, d);
            chk($sformatf("R4 masked row%0d", k), d, TBL[k].s & TBL[k].e);
            glb = 0; pwr = 0; lpmc = 0; hpmc = 0;
            step();
        end

        // R1 sticky capture and R2 partial clear
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'd0);
        src = 32'hF; step(); src = '0; step(); step();
        rd(2'd0, d); chk("R1 sticky", d, 32'hF);
        wr(2'd0, 32'h5);
        rd(2'd0, d); chk("R2 partial clear", d, 32'hA);

        // R3 set beats clear
        wr(2'd0, 32'hFFFF_FFFF);
        src = 32'h2;
        wr(2'd0, 32'h2);
        src = '0;
        rd(2'd0, d); chk("R3 set wins", d, 32'h2);
        wr(2'd0, 32'h2);
        rd(2'd0, d); chk("R2 clear after", d, 32'h0);

        // R4 ignored writes
        wr(2'd1, 32'h3);
        src = 32'h1; step(); src = '0;
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, d); chk("R4 enab kept", d, 32'h3);
        rd(2'd0, d); chk("R4 pend kept", d, 32'h1);
        rd(2'd3, d); chk("R4 rsvd zero", d, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);

        // R5 latency and clear timing
        wr(2'd1, 32'h80);
        glb = 1; step();
        src = 32'h80; step(); src = '0;
        chk("R5 not yet", {31'd0, irq}, 32'd0);
        step();
        chk("R5 req", {31'd0, irq}, 32'd1);
        chk("R5 vec4", {27'd0, vec}, 32'd4);
        wr(2'd0, 32'h80);
        chk("R5 still registered", {31'd0, irq}, 32'd1);
        step();
        chk("R5 dropped", {31'd0, irq}, 32'd0);

        // R6 gating keeps pending, request follows enable
        glb = 0;
        src = 32'h80; step(); src = '0; step(); step();
        chk("R6 gated", {31'd0, irq}, 32'd0);
        rd(2'd0, d); chk("R6 pend kept", d, 32'h80);
        glb = 1; step();
        chk("R6 released", {31'd0, irq}, 32'd1);
        chk("R6 vec", {27'd0, vec}, 32'd4);

        // R7 non-maskable with global enable low
        glb = 0; hpmc = 1; step();
        chk("R7 hpmc", {31'd0, irq}, 32'd1);
        chk("R7 vec", {27'd0, vec}, 32'd1);
        hpmc = 0; step();
        chk("R9 idle vec", {27'd0, vec}, 32'd0);

        finish_run();
    end

endmodule